// File: doc/BRIEF.md
# UART Receiver Line Status Unit

This unit sits behind the bit-level receiver of a serial port and keeps the line status that software sees for received characters: data available, overrun, parity error, framing error and line break. The deserializer hands it one character at a time as a one-cycle strobe. The strobe carries the eight data bits and two error tags, one for bad parity and one for a missing stop bit. The unit also watches the raw serial line, counting bit periods while the line is low, so that it can recognise a break on its own.

Characters are held either in a single holding register or in a receive queue whose depth is a parameter, chosen by a mode input. Each queued character keeps its parity, framing and break tags with it. In queue mode a character's error state reaches the status flags only when that character becomes the oldest entry. In single-register mode it reaches them at once. The error flags are sticky until a status read. The data-available flag follows the buffer occupancy.

Top module: `uart_rx_line_status`

## Requirements
- R1: `st_dr` is 1 exactly while one or more characters are buffered. In single-register mode a data read clears it. In queue mode it clears when the read empties the queue.
- R2: With `fifo_en`=1 the queue holds up to DEPTH characters and returns them on `head_data` in arrival order. Each `rd_data` pulse removes the oldest one.
- R3: With `fifo_en`=1, a character that arrives while DEPTH characters are queued sets `st_oe`. That character is discarded and the queued characters are left unchanged.
- R4: With `fifo_en`=0, a character that arrives while the holding register is occupied sets `st_oe` and replaces the held character.
- R5: With `fifo_en`=1, a character's tags (parity to `st_pe`, framing to `st_fe`, break to `st_bi`) set the flags only in the cycle that character becomes the oldest queued entry.
- R6: With `fifo_en`=0, a character's tags set the flags in the same cycle the character appears on `head_data`.
- R7: When `rx_line` stays low across more than `frame_bits` `bit_tick` pulses, the unit buffers one character of value 0x00 carrying the break, framing and parity tags. It is therefore reported with `st_bi`, `st_fe` and `st_pe` all set.
- R8: A single low period produces at most one break character. A new break can be detected only after `rx_line` has returned high.
- R9: A `rd_status` pulse clears `st_oe`, `st_pe`, `st_fe` and `st_bi` and leaves `st_dr` and `head_data` unchanged. A flag set in the same cycle as the read remains set.
- R10: The parity tag of a received character is ignored while `par_en`=0.
- R11: After reset, `st_dr`, `st_oe`, `st_pe`, `st_fe` and `st_bi` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects single holding register |
| par_en | input | 1 | Enables reporting of the character parity tag |
| frame_bits | input | 4 | Bit periods in one frame (start, data, parity, stop) |
| rx_line | input | 1 | Serial input level, synchronous to clk |
| bit_tick | input | 1 | One-cycle pulse once per bit period |
| chr_valid | input | 1 | One-cycle strobe: a character has been received |
| chr_data | input | 8 | Received character |
| chr_perr | input | 1 | Parity tag of the received character |
| chr_ferr | input | 1 | Framing tag of the received character |
| rd_data | input | 1 | Read pulse: remove the oldest buffered character |
| rd_status | input | 1 | Status read pulse: clear the sticky error flags |
| head_data | output | 8 | Oldest buffered character |
| st_dr | output | 1 | Data available |
| st_oe | output | 1 | Overrun seen |
| st_pe | output | 1 | Parity error seen |
| st_fe | output | 1 | Framing error seen |
| st_bi | output | 1 | Break seen |

## Verification
The assertions assume that `fifo_en` changes only while the buffer is empty. They also assume that the deserializer never sends a character strobe in the cycle a break character is inserted, and that `rx_line` is already synchronous to `clk`. The bench satisfies these conditions. It changes mode only after it has drained the buffer. It drives the break scenario with `chr_valid` held low. All stimulus is applied on the falling edge, so every input is stable for the clock edge that samples it.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              bi;
    logic              fe;
    logic              pe;
    logic [CHAR_W-1:0] data;
  } lsu_ent_t;
endpackage

// File: rtl/lsu_break_det.sv
module lsu_break_det #(
  parameter int FB_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_line,
  input  logic            bit_tick,
  input  logic [FB_W-1:0] frame_bits,
  output logic            brk
);
  logic [FB_W-1:0] low_cnt;
  logic            fired;
  logic            fire;

  // Fires on the first tick after frame_bits low periods have been counted.
  assign fire = !rx_line && bit_tick && (low_cnt == frame_bits) && !fired;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      fired   <= 1'b0;
      brk     <= 1'b0;
    end else begin
      brk <= fire;
      if (rx_line) begin
        low_cnt <= '0;
        fired   <= 1'b0;
      end else begin
        if (bit_tick && low_cnt != frame_bits) low_cnt <= low_cnt + 1'b1;
        if (fire) fired <= 1'b1;
      end
    end
  end

  p_brk_low_r7: assert property (@(posedge clk) disable iff (rst)
    brk |-> $past(!rx_line));
  p_one_brk_r8: assert property (@(posedge clk) disable iff (rst)
    brk |=> !brk);
endmodule

// File: rtl/lsu_rx_fifo.sv
module lsu_rx_fifo
  import lsu_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     fifo_en,
  input  logic     push,
  input  lsu_ent_t push_ent,
  input  logic     pop,
  output lsu_ent_t head_q,
  output logic     head_ld,
  output lsu_ent_t head_nx,
  output logic     ovr,
  output logic     dr
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  lsu_ent_t          mem [DEPTH];
  logic [PW-1:0]     wp, rp;
  logic [CW-1:0]     cnt, cnt_nx;
  logic              do_pop, full, accept, to_head, wr_mem, rd_mem;

  assign do_pop  = pop && (cnt != '0);
  assign full    = fifo_en ? (cnt == CW'(DEPTH)) : (cnt != '0);
  assign accept  = push && (!full || do_pop);
  assign ovr     = push && full && !do_pop;
  // Incoming character becomes the head directly.
  assign to_head = (accept && (cnt == '0 || (do_pop && cnt == CW'(1))))
                   || (ovr && !fifo_en);
  assign wr_mem  = accept && !to_head;
  assign rd_mem  = do_pop && (cnt > CW'(1));
  assign head_ld = to_head || rd_mem;
  assign head_nx = to_head ? push_ent : mem[rp];
  assign cnt_nx  = cnt + CW'(accept) - CW'(do_pop);

  always_ff @(posedge clk) begin
    if (wr_mem) mem[wp] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      dr     <= 1'b0;
      head_q <= '0;
    end else begin
      cnt <= cnt_nx;
      dr  <= (cnt_nx != '0);
      if (wr_mem) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (rd_mem) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (head_ld) head_q <= head_nx;
    end
  end

  p_cnt_cap_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  p_drop_keeps_r3: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && ovr) |=> ($stable(head_q) && $stable(cnt)));
  p_single_cap_r4: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |-> cnt <= CW'(1));
  p_dr_tracks_r1: assert property (@(posedge clk) disable iff (rst)
    dr == (cnt != '0));
endmodule

// File: rtl/lsu_status.sv
module lsu_status
  import lsu_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     rd_status,
  input  logic     head_ld,
  input  lsu_ent_t head_nx,
  input  logic     ovr,
  output logic     st_oe,
  output logic     st_pe,
  output logic     st_fe,
  output logic     st_bi
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st_oe <= 1'b0;
      st_pe <= 1'b0;
      st_fe <= 1'b0;
      st_bi <= 1'b0;
    end else begin
      st_oe <= (st_oe && !rd_status) || ovr;
      st_pe <= (st_pe && !rd_status) || (head_ld && head_nx.pe);
      st_fe <= (st_fe && !rd_status) || (head_ld && head_nx.fe);
      st_bi <= (st_bi && !rd_status) || (head_ld && head_nx.bi);
    end
  end

  p_oe_set_r3: assert property (@(posedge clk) disable iff (rst)
    ovr |=> st_oe);
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_status && !ovr && !head_ld) |=> !(st_oe || st_pe || st_fe || st_bi));
  p_bi_tags_r7: assert property (@(posedge clk) disable iff (rst)
    (head_ld && head_nx.bi) |=> (st_fe && st_pe));
endmodule

// File: rtl/uart_rx_line_status.sv
module uart_rx_line_status
  import lsu_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int FB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_en,
  input  logic              par_en,
  input  logic [FB_W-1:0]   frame_bits,
  input  logic              rx_line,
  input  logic              bit_tick,
  input  logic              chr_valid,
  input  logic [CHAR_W-1:0] chr_data,
  input  logic              chr_perr,
  input  logic              chr_ferr,
  input  logic              rd_data,
  input  logic              rd_status,
  output logic [CHAR_W-1:0] head_data,
  output logic              st_dr,
  output logic              st_oe,
  output logic              st_pe,
  output logic              st_fe,
  output logic              st_bi
);
  logic     brk, push, head_ld, ovr;
  lsu_ent_t push_ent, head_q, head_nx;

  lsu_break_det #(.FB_W(FB_W)) u_brk (
    .clk(clk), .rst(rst), .rx_line(rx_line), .bit_tick(bit_tick),
    .frame_bits(frame_bits), .brk(brk)
  );

  // A break inserts an all-zero character carrying every error tag.
  always_comb begin
    push = brk || chr_valid;
    if (brk) begin
      push_ent = '{bi: 1'b1, fe: 1'b1, pe: 1'b1, data: '0};
    end else begin
      push_ent = '{bi: 1'b0, fe: chr_ferr, pe: chr_perr && par_en, data: chr_data};
    end
  end

  lsu_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .push(push), .push_ent(push_ent),
    .pop(rd_data), .head_q(head_q), .head_ld(head_ld), .head_nx(head_nx),
    .ovr(ovr), .dr(st_dr)
  );

  lsu_status u_stat (
    .clk(clk), .rst(rst), .rd_status(rd_status), .head_ld(head_ld),
    .head_nx(head_nx), .ovr(ovr), .st_oe(st_oe), .st_pe(st_pe),
    .st_fe(st_fe), .st_bi(st_bi)
  );

  assign head_data = head_q.data;

  p_parity_gate_r10: assert property (@(posedge clk) disable iff (rst)
    (chr_valid && !brk && !par_en && !st_pe && !rd_status && !st_dr) |=> !st_pe);
endmodule

// File: tb/uart_rx_line_status_tb.sv
module uart_rx_line_status_tb;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_en = 1'b0, par_en = 1'b0;
  logic [3:0] frame_bits = 4'd10;
  logic       rx_line = 1'b1, bit_tick = 1'b0;
  logic       chr_valid = 1'b0, chr_perr = 1'b0, chr_ferr = 1'b0;
  logic [7:0] chr_data = '0;
  logic       rd_data = 1'b0, rd_status = 1'b0;
  logic [7:0] head_data;
  logic       st_dr, st_oe, st_pe, st_fe, st_bi;
  int         total = 0, bad = 0;

  always #2.5 clk = ~clk;

  uart_rx_line_status #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .par_en(par_en),
    .frame_bits(frame_bits), .rx_line(rx_line), .bit_tick(bit_tick),
    .chr_valid(chr_valid), .chr_data(chr_data), .chr_perr(chr_perr),
    .chr_ferr(chr_ferr), .rd_data(rd_data), .rd_status(rd_status),
    .head_data(head_data), .st_dr(st_dr), .st_oe(st_oe), .st_pe(st_pe),
    .st_fe(st_fe), .st_bi(st_bi)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic pe, input logic fe);
    chr_valid = 1'b1; chr_data = d; chr_perr = pe; chr_ferr = fe;
    @(negedge clk);
    chr_valid = 1'b0; chr_perr = 1'b0; chr_ferr = 1'b0;
  endtask

  task automatic pop_data();
    rd_data = 1'b1;
    @(negedge clk);
    rd_data = 1'b0;
  endtask

  task automatic read_status();
    rd_status = 1'b1;
    @(negedge clk);
    rd_status = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R11 dr", st_dr, 0);
    check("R11 flags", {st_oe, st_pe, st_fe, st_bi}, 0);
  endtask

  task automatic t_single();
    fifo_en = 1'b0;
    send(8'hA5, 1'b0, 1'b1);
    check("R6 head", head_data, 8'hA5);
    check("R6 fe immediate", st_fe, 1);
    check("R1 dr set", st_dr, 1);
    read_status();
    check("R9 fe cleared", st_fe, 0);
    check("R9 dr kept", st_dr, 1);
    check("R9 head kept", head_data, 8'hA5);
    send(8'h3C, 1'b0, 1'b0);
    check("R4 oe", st_oe, 1);
    check("R4 overwrite", head_data, 8'h3C);
    pop_data();
    check("R1 dr cleared", st_dr, 0);
    check("R9 oe sticky until read", st_oe, 1);
    read_status();
    check("R9 oe cleared", st_oe, 0);
  endtask

  task automatic t_parity();
    fifo_en = 1'b0;
    par_en = 1'b0;
    send(8'h55, 1'b1, 1'b0);
    check("R10 pe ignored", st_pe, 0);
    pop_data();
    par_en = 1'b1;
    send(8'h66, 1'b1, 1'b0);
    check("R10 pe reported", st_pe, 1);
    pop_data();
    read_status();
  endtask

  task automatic t_queue_tags();
    fifo_en = 1'b1;
    par_en = 1'b1;
    send(8'h11, 1'b0, 1'b0);
    send(8'h22, 1'b1, 1'b0);
    send(8'h33, 1'b0, 1'b0);
    check("R5 pe hidden", st_pe, 0);
    check("R2 head first", head_data, 8'h11);
    pop_data();
    check("R2 head second", head_data, 8'h22);
    check("R5 pe revealed", st_pe, 1);
    read_status();
    check("R9 pe cleared", st_pe, 0);
    pop_data();
    check("R2 head third", head_data, 8'h33);
    check("R5 clean head", st_pe, 0);
    check("R1 dr nonempty", st_dr, 1);
    pop_data();
    check("R1 dr empty", st_dr, 0);
  endtask

  task automatic t_queue_overrun();
    fifo_en = 1'b1;
    for (int i = 0; i < DEPTH; i++) send(8'(i + 8'h40), 1'b0, 1'b0);
    check("R3 no oe when full", st_oe, 0);
    send(8'hEE, 1'b0, 1'b0);
    check("R3 oe", st_oe, 1);
    for (int i = 0; i < DEPTH; i++) begin
      check("R2 order", head_data, 8'(i + 8'h40));
      pop_data();
    end
    check("R3 dropped char absent", st_dr, 0);
    read_status();
  endtask

  task automatic t_break();
    fifo_en = 1'b1;
    frame_bits = 4'd10;
    rx_line = 1'b0;
    ticks(10);
    @(negedge clk);
    check("R7 no break at frame time", st_dr, 0);
    ticks(1);
    @(negedge clk);
    check("R7 break char", st_dr, 1);
    check("R7 break data", head_data, 8'h00);
    check("R7 tags", {st_bi, st_fe, st_pe}, 3'b111);
    ticks(20);
    read_status();
    pop_data();
    check("R8 single char", st_dr, 0);
    check("R8 no new flags", {st_bi, st_fe, st_pe}, 0);
    rx_line = 1'b1;
    ticks(1);
    rx_line = 1'b0;
    ticks(11);
    @(negedge clk);
    check("R8 rearmed", st_dr, 1);
    check("R8 rearmed bi", st_bi, 1);
    rx_line = 1'b1;
    pop_data();
    read_status();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_parity();
    t_queue_tags();
    t_queue_overrun();
    t_break();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule